// File: doc/BRIEF.md
# Fuse-programmed sum-of-products array

This block is the logic plane of a small programmable device. Twenty-two input signals each drive two array columns, one true and one inverted. A flat configuration vector, indexed by fuse number, decides which columns feed each of 132 product terms. The terms are grouped into ten OR sums of uneven size, with 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 terms. Each sum has its own enable term. One reset term and one set term are shared by all outputs.

The configuration is loaded before operation and held stable. The block also passes through the two select bits that a downstream output cell reads for each output: one for polarity and one for registered mode. Every output is purely combinational. The block has no clock and no handshake. Its inputs are plain levels and its outputs follow them after settling.

Top module: `pal_sop_array`

## Requirements
- R1: Column 2k carries `in_sig[k]` and column 2k+1 carries its inverse. A product term is the AND of every column whose fuse is 0 (unblown). A column whose fuse is 1 (blown) drops out of the term.
- R2: Fuse number = 44 × row + column. Each row is one product term of 44 fuses, and bit n of `fuse_map` is fuse n.
- R3: Row 0 (fuses 0 to 43) drives `areset_term`. Row 131 (fuses 5764 to 5807) drives `sset_term`.
- R4: Output o has a group of rows. The first row of the group is the enable term on `oe_term[o]`, and the sum terms follow it directly. The groups start at fuses 44, 440, 924, 1496, 2156, 2904, 3652, 4312, 4884 and 5368, and the sums have 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 terms.
- R5: `sum_out[o]` is the OR of the sum terms of group o only. The enable row of the group is not part of the sum.
- R6: A term with every fuse unblown evaluates to 0 for any input, because it includes both a signal and its inverse.
- R7: A term with every fuse blown evaluates to 1 for any input.
- R8: `sel_polarity[o]` is fuse 5808+2o and `sel_register[o]` is fuse 5809+2o.
- R9: All outputs are combinational. A change on `in_sig` reaches the outputs within the same clock period, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fuse_map | input | 5828 | Configuration vector; bit n is fuse n, 1 means blown |
| in_sig | input | 22 | Array input signals |
| sum_out | output | 10 | OR sum for each output |
| oe_term | output | 10 | Enable term for each output |
| areset_term | output | 1 | Shared asynchronous-reset term |
| sset_term | output | 1 | Shared synchronous-set term |
| sel_polarity | output | 10 | Polarity select bit for each output |
| sel_register | output | 10 | Registered-mode select bit for each output |

## Verification
The bench goes after the group boundaries. A design that shifted any group start by one row would put an enable row into a sum, or steal the first term of the next group. Either fault shows up as a sum that disagrees with the model under random maps. Single-column maps pin down the true/inverse column order; a design that swapped the two columns would return the inverted input. All-unblown and all-blown maps separate a term that wrongly ignores unblown fuses from one that ignores blown fuses. Random select bits catch a swapped polarity/register pair.

// File: rtl/pal_array_pkg.sv
package pal_array_pkg;
  localparam int NUM_SIG   = 22;
  localparam int NUM_COL   = 2 * NUM_SIG;
  localparam int NUM_OUT   = 10;
  localparam int MIN_TERMS = 8;
  localparam int TERM_STEP = 2;
  localparam int MAX_TERMS = MIN_TERMS + TERM_STEP * (NUM_OUT / 2 - 1);

  // Term count rises toward the middle outputs and falls symmetrically.
  function automatic int term_count(input int o);
    int k;
    k = (o < NUM_OUT / 2) ? o : (NUM_OUT - 1 - o);
    return MIN_TERMS + TERM_STEP * k;
  endfunction

  // First row of group o: row 0 is the reset term, then groups of (enable + sums).
  function automatic int group_row(input int o);
    int r;
    r = 1;
    for (int j = 0; j < o; j++) r += term_count(j) + 1;
    return r;
  endfunction

  localparam int SET_ROW   = group_row(NUM_OUT);
  localparam int NUM_ROWS  = SET_ROW + 1;
  localparam int SEL_BASE  = NUM_ROWS * NUM_COL;
  localparam int FUSE_BITS = SEL_BASE + 2 * NUM_OUT;
endpackage

// File: rtl/pal_col_driver.sv
module pal_col_driver #(
  parameter int NSIG = 22,
  localparam int NCOL = 2 * NSIG
) (
  input  logic [NSIG-1:0] in_sig,
  output logic [NCOL-1:0] cols
);
  // R1: even column true, odd column inverted
  for (genvar k = 0; k < NSIG; k++) begin : g_col
    assign cols[2*k]   = in_sig[k];
    assign cols[2*k+1] = ~in_sig[k];
  end
endmodule

// File: rtl/pal_pterm.sv
module pal_pterm #(
  parameter int NCOL = 44
) (
  input  logic [NCOL-1:0] cols,
  input  logic [NCOL-1:0] fuses,
  output logic            term
);
  // An unblown fuse (0) lets its column into the AND; a blown one forces a 1.
  assign term = &(cols | fuses);

  always_comb begin
    assert_unblown_zero_R6: assert (!((fuses == '0) && term))
      else $error("unblown row produced 1");
    assert_blown_one_R7: assert (!((fuses == '1) && !term))
      else $error("blown row produced 0");
  end
endmodule

// File: rtl/pal_or_group.sv
module pal_or_group #(
  parameter int NCOL   = 44,
  parameter int NTERMS = 8,
  localparam int WIDTH = NCOL * NTERMS
) (
  input  logic [NCOL-1:0]  cols,
  input  logic [WIDTH-1:0] fuses,
  output logic             sum
);
  logic [NTERMS-1:0] terms;

  for (genvar t = 0; t < NTERMS; t++) begin : g_term
    pal_pterm #(.NCOL(NCOL)) u_term (
      .cols (cols),
      .fuses(fuses[t*NCOL +: NCOL]),
      .term (terms[t])
    );
  end

  assign sum = |terms;

  always_comb begin
    // R5: a true sum needs at least one term with some blown fuse
    assert_sum_needs_blown_R5: assert (!(sum && (fuses == '0)))
      else $error("sum high with all fuses unblown");
    assert_full_blown_sum_R7: assert (!((fuses == '1) && !sum))
      else $error("sum low with all fuses blown");
  end
endmodule

// File: rtl/pal_sop_array.sv
module pal_sop_array
  import pal_array_pkg::*;
(
  input  logic [FUSE_BITS-1:0] fuse_map,
  input  logic [NUM_SIG-1:0]   in_sig,
  output logic [NUM_OUT-1:0]   sum_out,
  output logic [NUM_OUT-1:0]   oe_term,
  output logic                 areset_term,
  output logic                 sset_term,
  output logic [NUM_OUT-1:0]   sel_polarity,
  output logic [NUM_OUT-1:0]   sel_register
);
  logic [NUM_COL-1:0] cols;

  pal_col_driver #(.NSIG(NUM_SIG)) u_cols (
    .in_sig(in_sig),
    .cols  (cols)
  );

  // R3: shared rows at the two ends of the array
  pal_pterm #(.NCOL(NUM_COL)) u_areset (
    .cols (cols),
    .fuses(fuse_map[0 +: NUM_COL]),
    .term (areset_term)
  );

  pal_pterm #(.NCOL(NUM_COL)) u_sset (
    .cols (cols),
    .fuses(fuse_map[SET_ROW*NUM_COL +: NUM_COL]),
    .term (sset_term)
  );

  // R4: one group per output, enable row first then its sum rows
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    localparam int ROW0   = group_row(o);
    localparam int NTERMS = term_count(o);

    pal_pterm #(.NCOL(NUM_COL)) u_oe (
      .cols (cols),
      .fuses(fuse_map[ROW0*NUM_COL +: NUM_COL]),
      .term (oe_term[o])
    );

    pal_or_group #(.NCOL(NUM_COL), .NTERMS(NTERMS)) u_sum (
      .cols (cols),
      .fuses(fuse_map[(ROW0+1)*NUM_COL +: NUM_COL*NTERMS]),
      .sum  (sum_out[o])
    );

    // R8: even address polarity, odd address register mode
    assign sel_polarity[o] = fuse_map[SEL_BASE + 2*o];
    assign sel_register[o] = fuse_map[SEL_BASE + 2*o + 1];
  end

  always_comb begin
    assert_reset_row_unblown_R6: assert (!(areset_term && (fuse_map[0 +: NUM_COL] == '0)))
      else $error("reset term high with unblown row");
  end
endmodule

// File: tb/pal_sop_array_tb.sv
module pal_sop_array_tb;
  import pal_array_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [FUSE_BITS-1:0] fuse_map;
  logic [NUM_SIG-1:0]   in_sig;
  logic [NUM_OUT-1:0]   sum_out, oe_term, sel_polarity, sel_register;
  logic                 areset_term, sset_term;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Layout taken from the requirements (R3, R4, R8)
  int first_fuse [10] = '{44, 440, 924, 1496, 2156, 2904, 3652, 4312, 4884, 5368};
  int n_terms    [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

  pal_sop_array u_dut (
    .fuse_map    (fuse_map),
    .in_sig      (in_sig),
    .sum_out     (sum_out),
    .oe_term     (oe_term),
    .areset_term (areset_term),
    .sset_term   (sset_term),
    .sel_polarity(sel_polarity),
    .sel_register(sel_register)
  );

  // Reference term per R1/R2
  function automatic bit ref_term(int row);
    bit v = 1'b1;
    for (int c = 0; c < 44; c++) begin
      bit colv = c[0] ? ~in_sig[c/2] : in_sig[c/2];
      if (fuse_map[row*44 + c] == 1'b0 && colv == 1'b0) v = 1'b0;
    end
    return v;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic compare_all();
    for (int o = 0; o < 10; o++) begin
      bit s = 1'b0;
      int r0 = first_fuse[o] / 44;
      for (int t = 0; t < n_terms[o]; t++) s |= ref_term(r0 + 1 + t);
      check("R5 sum", int'(sum_out[o]), int'(s));
      check("R4 oe", int'(oe_term[o]), int'(ref_term(r0)));
      check("R8 polarity", int'(sel_polarity[o]), int'(fuse_map[5808 + 2*o]));
      check("R8 register", int'(sel_register[o]), int'(fuse_map[5809 + 2*o]));
    end
    check("R3 areset", int'(areset_term), int'(ref_term(0)));
    check("R3 sset", int'(sset_term), int'(ref_term(131)));
  endtask

  task automatic random_map();
    for (int r = 0; r < 132; r++) begin
      int mode = int'($urandom % 4);
      for (int c = 0; c < 44; c++) begin
        case (mode)
          0: fuse_map[r*44 + c] = 1'b1;
          1: fuse_map[r*44 + c] = 1'b0;
          2: fuse_map[r*44 + c] = ($urandom % 6) != 0;
          default: fuse_map[r*44 + c] = ($urandom % 22) != 0;
        endcase
      end
    end
    for (int b = 5808; b < 5828; b++) fuse_map[b] = $urandom % 2;
  endtask

  task automatic apply_in(logic [NUM_SIG-1:0] v);
    @(posedge clk);
    in_sig = v;
    #2;
  endtask

  initial begin
    fuse_map = '0;
    in_sig = '0;
    // R6: every fuse unblown -> all terms 0
    for (int i = 0; i < 4; i++) begin
      apply_in(NUM_SIG'($urandom));
      check("R6 sums zero", int'(sum_out), 0);
      check("R6 oe zero", int'(oe_term), 0);
      check("R6 areset zero", int'(areset_term), 0);
      check("R6 sset zero", int'(sset_term), 0);
    end
    // R7: every fuse blown -> all terms 1, selects 1
    fuse_map = '1;
    for (int i = 0; i < 4; i++) begin
      apply_in(NUM_SIG'($urandom));
      check("R7 sums one", int'(sum_out), 1023);
      check("R7 oe one", int'(oe_term), 1023);
      check("R7 areset one", int'(areset_term), 1);
      check("R7 sset one", int'(sset_term), 1);
      check("R8 selects", int'({sel_register, sel_polarity}), 20'hFFFFF);
    end
    // R1: single unblown column 10 (true of signal 5) in first term of output 3
    fuse_map = '1;
    for (int r = 0; r < 132; r++) fuse_map[r*44 +: 44] = '1;
    for (int o = 0; o < 10; o++)
      for (int t = 0; t < n_terms[o]; t++) fuse_map[first_fuse[o] + 44*(t+1) +: 44] = '0;
    fuse_map[first_fuse[3] + 44 +: 44] = '1;
    fuse_map[first_fuse[3] + 44 + 10] = 1'b0;
    apply_in(22'h000020);
    check("R1 true column high", int'(sum_out[3]), 1);
    check("R5 other sums", int'(sum_out & 10'h3F7), 0);
    apply_in(22'h3FFFDF);
    check("R1 true column low", int'(sum_out[3]), 0);
    // R1: inverted column 11
    fuse_map[first_fuse[3] + 44 + 10] = 1'b1;
    fuse_map[first_fuse[3] + 44 + 11] = 1'b0;
    #1;
    check("R9 map change no clock", int'(sum_out[3]), 1);
    // R9: input change mid-cycle
    in_sig = 22'h000020;
    #1;
    check("R9 input change no clock", int'(sum_out[3]), 0);
    // R4/R5: last term of output 4 only, enable row of output 5 stays out of sum 4
    for (int o = 0; o < 10; o++)
      for (int t = 0; t < n_terms[o]; t++) fuse_map[first_fuse[o] + 44*(t+1) +: 44] = '0;
    fuse_map[first_fuse[4] + 44*16 +: 44] = '1;
    apply_in(NUM_SIG'($urandom));
    check("R4 last term of group 4", int'(sum_out), 10'h010);
    // Random maps against the model
    for (int m = 0; m < 40; m++) begin
      random_map();
      for (int v = 0; v < 20; v++) begin
        apply_in(NUM_SIG'($urandom));
        compare_all();
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule